// File: doc/BRIEF.md
# Floating-Point Exception Status and Trap Control

This block holds the exception state of a floating-point unit that is visible to software. Every completing floating-point operation reports five exception bits. The block gathers them into sticky status flags. Next to the flags sits a mask of trap enables, one per exception. Both live in one 10-bit control register, which software reads and writes through a plain register port. An exception whose enable is clear leaves only its flag behind, and the operation finishes with its default result.

An exception whose enable is set raises a trap request. To let a handler locate the instruction that faulted, the block keeps a short in-order queue of the PC and opcode of every floating-point instruction that has issued but not yet completed. Completions always retire the oldest entry.

When a trap is taken:
- The queue freezes.
- The faulting instruction's PC and opcode are presented on the trap outputs.
- The pipeline must hold off until the handler acknowledges the trap.
- The acknowledge flushes the queue.

Top module: `fpx_ctrl`

## Requirements
- R1: Exception inputs and register flag bits use one order: bit 4 invalid, bit 3 divide-by-zero, bit 2 overflow, bit 1 underflow, bit 0 inexact. An accepted completion ORs its exception bits into the flags. The result is visible on `reg_rdata[4:0]` one cycle later. A set flag stays set until a register write changes it.
- R2: A register write loads flags from `reg_wdata[4:0]` and enables from `reg_wdata[9:5]`. It shows on `reg_rdata` in the next cycle. Exceptions of a completion accepted in the same cycle are ORed on top of the written flags.
- R3: Synchronous reset clears all flags and enables, empties the queue and drops `trap_req`. `iss_ready` is high after reset.
- R4: A completion whose exception bits have no matching enable sets only its flags. It raises no trap and retires the oldest queue entry.
- R5: A completion with any exception bit whose enable is set raises `trap_req` in the next cycle. `trap_pc` and `trap_op` then show the oldest queue entry, which is the faulting instruction. Its flags are still updated. The trap decision uses the enables held before any same-cycle write.
- R6: The queue holds 4 instructions in issue order. `iss_ready` is low while 4 are in flight. An issue with `iss_ready` low is ignored.
- R7: While `trap_req` is high:
  - issues are refused;
  - completions change neither flags nor the queue;
  - register writes still take effect.
- R8: `trap_ack` while `trap_req` is high clears `trap_req` in the next cycle and empties the queue.
- R9: A completion while the queue is empty is ignored, and no flag changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | An FP instruction issues this cycle |
| iss_pc | input | 32 | PC of the issuing instruction |
| iss_op | input | 8 | Opcode of the issuing instruction |
| iss_ready | output | 1 | Queue can accept an issue |
| cmp_valid | input | 1 | Oldest in-flight instruction completes |
| cmp_exc | input | 5 | Exception bits of the completion |
| reg_wr | input | 1 | Write strobe for the control register |
| reg_wdata | input | 10 | Write data: enables 9:5, flags 4:0 |
| reg_rdata | output | 10 | Current control register |
| trap_req | output | 1 | Trap pending |
| trap_ack | input | 1 | Handler done; clear trap and flush |
| trap_pc | output | 32 | PC of the faulting instruction |
| trap_op | output | 8 | Opcode of the faulting instruction |

## Verification
A corrupted queue pointer or count shows up at the next trap. In that case `trap_pc` names an instruction other than the oldest unretired one, and `iss_ready` falls or rises at the wrong fill level within a few issues. A lost or spurious flag bit is visible on `reg_rdata` one cycle after the completion that should have set it. A wrong trap decision shows up the cycle after the completion, as `trap_req` differing from the enable mask. Every cycle the bench compares all of these against an independent model, under random traffic and directed corner cases.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int NEXC    = 5;
  localparam int CSR_W   = 2 * NEXC;
  localparam int EXC_INV = 4;
  localparam int EXC_DZ  = 3;
  localparam int EXC_OVF = 2;
  localparam int EXC_UNF = 1;
  localparam int EXC_INX = 0;
  typedef logic [NEXC-1:0] exc_t;
endpackage

// File: rtl/fpx_csr.sv
module fpx_csr
  import fpx_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [CSR_W-1:0] wdata,
  input  logic             fire,
  input  exc_t             exc,
  output exc_t             flags,
  output exc_t             enables
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flags   <= '0;
      enables <= '0;
    end else begin
      flags <= (wr ? wdata[NEXC-1:0] : flags) | (fire ? exc : '0);
      if (wr) enables <= wdata[CSR_W-1:NEXC];
    end
  end

  assert_sticky_flags_R1: assert property (@(posedge clk) disable iff (rst)
    !wr |=> (($past(flags) & ~flags) == '0));
  assert_fire_sets_R1: assert property (@(posedge clk) disable iff (rst)
    fire |=> ((flags & $past(exc)) == $past(exc)));
endmodule

// File: rtl/fpx_inflight_q.sv
module fpx_inflight_q #(
  parameter int DEPTH = 4,
  parameter int PC_W  = 32,
  parameter int OP_W  = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            push,
  input  logic [PC_W-1:0] push_pc,
  input  logic [OP_W-1:0] push_op,
  input  logic            pop,
  input  logic            flush,
  input  logic            freeze,
  output logic [PC_W-1:0] head_pc,
  output logic [OP_W-1:0] head_op,
  output logic            full,
  output logic            empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int ENT_W = PC_W + OP_W;

  logic [ENT_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] rd_ptr, wr_ptr;
  logic [CNT_W-1:0] count;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (count == CNT_W'(DEPTH));
  assign empty = (count == '0);
  assign {head_pc, head_op} = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= {push_pc, push_op};
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  assert_no_push_full_R6: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
  assert_no_pop_empty_R9: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
  assert_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    (freeze && !flush) |=> (count == $past(count) && rd_ptr == $past(rd_ptr)));
  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (rst)
    flush |=> empty);
endmodule

// File: rtl/fpx_trap_latch.sv
module fpx_trap_latch #(
  parameter int PC_W = 32,
  parameter int OP_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            take,
  input  logic            ack,
  input  logic [PC_W-1:0] head_pc,
  input  logic [OP_W-1:0] head_op,
  output logic            trap_req,
  output logic [PC_W-1:0] trap_pc,
  output logic [OP_W-1:0] trap_op
);
  always_ff @(posedge clk) begin
    if (rst) begin
      trap_req <= 1'b0;
      trap_pc  <= '0;
      trap_op  <= '0;
    end else if (trap_req) begin
      if (ack) trap_req <= 1'b0;
    end else if (take) begin
      trap_req <= 1'b1;
      trap_pc  <= head_pc;
      trap_op  <= head_op;
    end
  end

  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (trap_req && ack) |=> !trap_req);
  assert_trap_pc_held_R5: assert property (@(posedge clk) disable iff (rst)
    (trap_req && !ack) |=> (trap_req && $stable(trap_pc) && $stable(trap_op)));
endmodule

// File: rtl/fpx_ctrl.sv
module fpx_ctrl
  import fpx_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int OP_W  = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             iss_valid,
  input  logic [PC_W-1:0]  iss_pc,
  input  logic [OP_W-1:0]  iss_op,
  output logic             iss_ready,
  input  logic             cmp_valid,
  input  logic [NEXC-1:0]  cmp_exc,
  input  logic             reg_wr,
  input  logic [CSR_W-1:0] reg_wdata,
  output logic [CSR_W-1:0] reg_rdata,
  output logic             trap_req,
  input  logic             trap_ack,
  output logic [PC_W-1:0]  trap_pc,
  output logic [OP_W-1:0]  trap_op
);
  exc_t flags, enables;
  logic full, empty, fire, take, pop, push, flush;
  logic [PC_W-1:0] head_pc;
  logic [OP_W-1:0] head_op;

  assign iss_ready = !full && !trap_req;
  assign push      = iss_valid && iss_ready;
  assign fire      = cmp_valid && !empty && !trap_req;
  assign take      = fire && ((cmp_exc & enables) != '0);
  assign pop       = fire && !take;
  assign flush     = trap_req && trap_ack;
  assign reg_rdata = {enables, flags};

  fpx_csr u_csr (
    .clk(clk), .rst(rst), .wr(reg_wr), .wdata(reg_wdata),
    .fire(fire), .exc(cmp_exc), .flags(flags), .enables(enables)
  );

  fpx_inflight_q #(.DEPTH(DEPTH), .PC_W(PC_W), .OP_W(OP_W)) u_q (
    .clk(clk), .rst(rst), .push(push), .push_pc(iss_pc), .push_op(iss_op),
    .pop(pop), .flush(flush), .freeze(trap_req),
    .head_pc(head_pc), .head_op(head_op), .full(full), .empty(empty)
  );

  fpx_trap_latch #(.PC_W(PC_W), .OP_W(OP_W)) u_trap (
    .clk(clk), .rst(rst), .take(take), .ack(trap_ack),
    .head_pc(head_pc), .head_op(head_op),
    .trap_req(trap_req), .trap_pc(trap_pc), .trap_op(trap_op)
  );

  assert_trap_only_enabled_R4: assert property (@(posedge clk) disable iff (rst)
    (!trap_req && (!cmp_valid || empty || ((cmp_exc & enables) == '0))) |=> !trap_req);
  assert_trap_on_enabled_R5: assert property (@(posedge clk) disable iff (rst)
    take |=> trap_req);
  assert_trap_flags_frozen_R7: assert property (@(posedge clk) disable iff (rst)
    (trap_req && !reg_wr) |=> $stable(flags));
endmodule

// File: tb/fpx_ctrl_test.sv
`timescale 1ns/1ps
module fpx_ctrl_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, iss_valid, iss_ready, cmp_valid, reg_wr, trap_req, trap_ack;
  logic [31:0] iss_pc, trap_pc;
  logic [7:0]  iss_op, trap_op;
  logic [4:0]  cmp_exc;
  logic [9:0]  reg_wdata, reg_rdata;

  fpx_ctrl uut (
    .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_pc(iss_pc), .iss_op(iss_op),
    .iss_ready(iss_ready), .cmp_valid(cmp_valid), .cmp_exc(cmp_exc),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .trap_req(trap_req), .trap_ack(trap_ack), .trap_pc(trap_pc), .trap_op(trap_op)
  );

  int checks = 0, fails = 0;
  logic [4:0]  m_f, m_e;
  logic [31:0] m_qpc [4];
  logic [7:0]  m_qop [4];
  int          m_head, m_cnt;
  logic        m_trap;
  logic [31:0] m_tpc;
  logic [7:0]  m_top;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic m_ready();
    return (m_cnt < 4) && !m_trap;
  endfunction

  task automatic step(string tag, logic iv, logic [31:0] ipc, logic [7:0] iop,
                      logic cv, logic [4:0] exc, logic wr, logic [9:0] wd, logic ack);
    logic fire, take, push, pop;
    int tail;
    @(negedge clk);
    iss_valid = iv; iss_pc = ipc; iss_op = iop; cmp_valid = cv; cmp_exc = exc;
    reg_wr = wr; reg_wdata = wd; trap_ack = ack;
    push = iv && m_ready();
    fire = cv && (m_cnt > 0) && !m_trap;
    take = fire && ((exc & m_e) != 0);
    pop  = fire && !take;
    tail = (m_head + m_cnt) % 4;
    if (wr) begin m_f = wd[4:0]; m_e = wd[9:5]; end
    if (fire) m_f = m_f | exc;
    if (m_trap) begin
      if (ack) begin m_trap = 1'b0; m_cnt = 0; m_head = 0; end
    end else begin
      if (take) begin m_trap = 1'b1; m_tpc = m_qpc[m_head]; m_top = m_qop[m_head]; end
      if (push) begin m_qpc[tail] = ipc; m_qop[tail] = iop; end
      if (pop) m_head = (m_head + 1) % 4;
      m_cnt = m_cnt + int'(push) - int'(pop);
    end
    @(posedge clk); #1;
    chk(tag, 64'(reg_rdata), 64'({m_e, m_f}));
    chk("R6 iss_ready", 64'(iss_ready), 64'(m_ready()));
    chk("R5 trap_req", 64'(trap_req), 64'(m_trap));
    if (m_trap) begin
      chk("R5 trap_pc", 64'(trap_pc), 64'(m_tpc));
      chk("R5 trap_op", 64'(trap_op), 64'(m_top));
    end
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int unused;
    unused = $urandom(20240611);
    iss_valid = 0; iss_pc = 0; iss_op = 0; cmp_valid = 0; cmp_exc = 0;
    reg_wr = 0; reg_wdata = 0; trap_ack = 0; rst = 1;
    m_f = 0; m_e = 0; m_head = 0; m_cnt = 0; m_trap = 0; m_tpc = 0; m_top = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0; #1;
    // R3: reset state
    chk("R3 rdata", 64'(reg_rdata), 64'd0);
    chk("R3 trap_req", 64'(trap_req), 64'd0);
    chk("R3 iss_ready", 64'(iss_ready), 64'd1);
    // R6: fill the queue to 4, then a refused 5th issue
    for (int i = 0; i < 5; i++)
      step("R6", 1, 32'h1000 + 32'(4*i), 8'(8'h40 + i), 0, 0, 0, 0, 0);
    // R4: inexact with no enables -> flag only, entry retired
    step("R4", 0, 0, 0, 1, 5'b00001, 0, 0, 0);
    // R2: enable invalid trap (bit 9), keep flags
    step("R2", 0, 0, 0, 0, 0, 1, 10'b10000_00001, 0);
    // R5: invalid on 2nd instruction -> trap names PC 0x1004
    step("R5", 0, 0, 0, 1, 5'b10000, 0, 0, 0);
    chk("R5 faulting pc", 64'(trap_pc), 64'h1004);
    // R7: completion ignored, issue refused, write still lands
    step("R7", 1, 32'h2000, 8'h11, 1, 5'b00100, 0, 0, 0);
    step("R7", 0, 0, 0, 0, 0, 1, 10'b10000_00000, 0);
    // R8: acknowledge flushes the queue
    step("R8", 0, 0, 0, 0, 0, 0, 0, 1);
    chk("R8 ready after flush", 64'(iss_ready), 64'd1);
    // R9: completion with empty queue ignored
    step("R9", 0, 0, 0, 1, 5'b11111, 0, 0, 0);
    chk("R9 flags unchanged", 64'(reg_rdata[4:0]), 64'd0);
    // R2: write and same-cycle completion combine
    step("R2", 1, 32'h3000, 8'h22, 0, 0, 0, 0, 0);
    step("R2", 0, 0, 0, 1, 5'b00010, 1, 10'b00000_01000, 0);
    chk("R2 merged flags", 64'(reg_rdata[4:0]), 64'b01010);
    // R1: random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [9:0] wd;
      wd = {5'($urandom) & 5'($urandom) & 5'($urandom), 5'($urandom)};
      step("R1", 1'($urandom % 3 != 0), $urandom, 8'($urandom),
           1'($urandom % 2), 5'($urandom) & 5'($urandom),
           1'($urandom % 16 == 0), wd, 1'($urandom % 4 == 0));
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule